// File: doc/BRIEF.md
# Synchronous Serial Transmit/Receive Engine with Tri-State Data Pin

This block is a master-side engine for a synchronous serial link that uses a short frame pulse to mark the start of each word. It takes a parallel word and a bit count through a valid/ready load port. It sends the word MSB first on a serial data pin and, in the same bit periods, samples a receive line into a parallel word. The serial clock comes from the system clock through a programmable divider. The engine also produces the frame pulse, which lasts one serial clock period. The start delay is always zero, because both clock and frame are generated here.

The data pin has its own output-enable signal. With tri-state mode off, the pin is always driven and holds the last bit between words. With tri-state mode on, the pin is driven only while a word is on the line, starting with the MSB. A late-release control picks when the pin is let go. Either it is released half a serial clock into the LSB period, or it is released at the rising edge that ends that period. A word can be queued while the engine is idle or during the LSB, so consecutive words follow each other with no idle period.

Top module: `ssp_tx_engine`

## Requirements
- R1: The number of bits per word is `len_i`+1; `len_i` values 0, 1 and 2 give 4 bits, so the range is 4 to 32. Bits leave MSB first, from bit `len_i` of the loaded word down to bit 0, one per serial clock period.
- R2: `sclk_o` starts low after reset and toggles every `div_i`+1 system clock cycles. `txd_o` changes only in a cycle in which `sclk_o` rises.
- R3: `frm_o` rises together with a rising edge of `sclk_o` and falls at the next rising edge. The MSB period starts at that falling edge.
- R4: With `tte_i`=0, `oe_o` is high at all times. After the last word, `txd_o` keeps the LSB of that word.
- R5: With `tte_i`=1, `oe_o` is low during the frame period and goes high at the rising edge that starts the MSB. It stays high through every bit period up to the LSB.
- R6: With `tte_i`=1 and `late_i`=0, `oe_o` falls at the falling `sclk_o` edge in the middle of the LSB period.
- R7: With `tte_i`=1 and `late_i`=1, `oe_o` stays high through the whole LSB period and falls at the rising edge that ends it.
- R8: `ld_ready_o` is high only when no word is waiting and the engine is either idle or in the LSB period. A word is taken on a cycle with `ld_valid_i` and `ld_ready_o` both high.
- R9: If a word has been taken by the rising edge that ends an LSB period, `frm_o` goes high at that same edge, with no idle period.
- R10: At the falling edge in the LSB period, `rx_valid_o` pulses for one system cycle. At the same time `rx_data_o` shows the sampled `rxd_i` bits, right-aligned (last bit in bit 0) with the unused upper bits zero. `rxd_i` is sampled on falling edges of `sclk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Serial half-period in system cycles, minus one |
| tte_i | input | 1 | Tri-state mode for the data pin |
| late_i | input | 1 | Release the data pin at the edge after the LSB instead of mid-LSB |
| ld_valid_i | input | 1 | Load request |
| ld_data_i | input | MAX_W | Word to send, right-aligned |
| len_i | input | LEN_W | Bits per word minus one (minimum 3) |
| ld_ready_o | output | 1 | Load can be accepted |
| sclk_o | output | 1 | Serial clock |
| frm_o | output | 1 | Frame pulse, one serial period |
| txd_o | output | 1 | Serial transmit data |
| oe_o | output | 1 | Drive enable for txd_o; low means high impedance |
| rxd_i | input | 1 | Serial receive data |
| rx_data_o | output | MAX_W | Last received word, right-aligned |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |

## Verification
The properties checked on every cycle are the edge relations. The data line only changes on a rising serial clock. The frame pulse starts and ends on rising edges and never spans two of them. The output enable changes only on serial clock edges, with the release edge set by the late-release control. The receive strobe only appears with a falling edge. The loader must be stalled while a frame is on the line. Only the bench's scenarios can show the rest. This covers the bit order and word length, the exact bit period in which ready opens, the seamless start of a queued word, and the idle hold of the LSB. It also covers the loopback value of the received word, under random lengths, random gaps and every mode and divider setting.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_SHIFT = 2'd2
  } ssp_state_e;
endpackage

// File: rtl/ssp_clk_gen.sv
module ssp_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             tick;

  assign tick   = (cnt_q >= div_i);
  assign rise_o = tick & ~sclk_q;
  assign fall_o = tick &  sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssp_hold.sv
module ssp_hold #(
  parameter int MAX_W = 32,
  parameter int LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_valid_i,
  input  logic [MAX_W-1:0] ld_data_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             win_i,
  input  logic             take_i,
  output logic             ready_o,
  output logic             avail_o,
  output logic [MAX_W-1:0] word_o,
  output logic [LEN_W-1:0] len_o
);
  logic             pend_q;
  logic [MAX_W-1:0] word_q;
  logic [LEN_W-1:0] len_q;
  logic             accept;

  assign ready_o = ~pend_q & win_i;
  assign accept  = ld_valid_i & ready_o;
  // bypass so a word accepted on a start edge is used at once
  assign avail_o = pend_q | accept;
  assign word_o  = pend_q ? word_q : ld_data_i;
  assign len_o   = pend_q ? len_q  : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      word_q <= '0;
      len_q  <= '0;
    end else if (take_i) begin
      pend_q <= 1'b0;
    end else if (accept) begin
      pend_q <= 1'b1;
      word_q <= ld_data_i;
      len_q  <= len_i;
    end
  end
endmodule

// File: rtl/ssp_seq.sv
module ssp_seq
  import ssp_pkg::*;
#(
  parameter int MAX_W = 32,
  parameter int LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             late_i,
  input  logic             avail_i,
  input  logic [MAX_W-1:0] word_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             rxd_i,
  output logic             take_o,
  output logic             win_o,
  output logic             frm_o,
  output logic             txd_o,
  output logic             drive_o,
  output logic [MAX_W-1:0] rx_data_o,
  output logic             rx_valid_o
);
  localparam logic [LEN_W-1:0] TOP = LEN_W'(MAX_W - 1);

  ssp_state_e       state_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic [MAX_W-1:0] sr_q;
  logic [MAX_W-1:0] rx_sr_q;
  logic             frm_q;
  logic             drive_q;
  logic             lsb;

  assign lsb     = (state_q == ST_SHIFT) && (cnt_q == '0);
  assign win_o   = (state_q == ST_IDLE) || lsb;
  assign take_o  = rise_i & avail_i & win_o;
  assign txd_o   = sr_q[MAX_W-1];
  assign frm_o   = frm_q;
  assign drive_o = drive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      len_q      <= '0;
      sr_q       <= '0;
      rx_sr_q    <= '0;
      frm_q      <= 1'b0;
      drive_q    <= 1'b0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (take_o) begin
        sr_q    <= word_i << (TOP - len_i);  // left-align, MSB on txd
        len_q   <= len_i;
        rx_sr_q <= '0;
        frm_q   <= 1'b1;
        drive_q <= 1'b0;
        state_q <= ST_FRAME;
      end else if (rise_i) begin
        unique case (state_q)
          ST_FRAME: begin
            frm_q   <= 1'b0;
            drive_q <= 1'b1;
            cnt_q   <= len_q;
            state_q <= ST_SHIFT;
          end
          ST_SHIFT: begin
            if (cnt_q == '0) begin
              drive_q <= 1'b0;
              state_q <= ST_IDLE;  // sr_q kept: txd holds LSB
            end else begin
              sr_q  <= sr_q << 1;
              cnt_q <= cnt_q - 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (fall_i && state_q == ST_SHIFT) begin
        rx_sr_q <= {rx_sr_q[MAX_W-2:0], rxd_i};
        if (cnt_q == '0) begin
          rx_data_o  <= {rx_sr_q[MAX_W-2:0], rxd_i};
          rx_valid_o <= 1'b1;
          if (!late_i) drive_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ssp_tx_engine.sv
module ssp_tx_engine #(
  parameter int MAX_W = 32,
  parameter int DIV_W = 8,
  parameter int LEN_W = $clog2(MAX_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tte_i,
  input  logic             late_i,
  input  logic             ld_valid_i,
  input  logic [MAX_W-1:0] ld_data_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             ld_ready_o,
  output logic             sclk_o,
  output logic             frm_o,
  output logic             txd_o,
  output logic             oe_o,
  input  logic             rxd_i,
  output logic [MAX_W-1:0] rx_data_o,
  output logic             rx_valid_o
);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(3);

  logic             rise, fall, win, take, avail, drive;
  logic [LEN_W-1:0] len_eff, len_sel;
  logic [MAX_W-1:0] word_sel;

  assign len_eff = (len_i < MIN_LEN) ? MIN_LEN : len_i;

  ssp_clk_gen #(.DIV_W(DIV_W)) i_clk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_i),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  ssp_hold #(.MAX_W(MAX_W), .LEN_W(LEN_W)) i_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_valid_i (ld_valid_i),
    .ld_data_i  (ld_data_i),
    .len_i      (len_eff),
    .win_i      (win),
    .take_i     (take),
    .ready_o    (ld_ready_o),
    .avail_o    (avail),
    .word_o     (word_sel),
    .len_o      (len_sel)
  );

  ssp_seq #(.MAX_W(MAX_W), .LEN_W(LEN_W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .fall_i     (fall),
    .late_i     (late_i),
    .avail_i    (avail),
    .word_i     (word_sel),
    .len_i      (len_sel),
    .rxd_i      (rxd_i),
    .take_o     (take),
    .win_o      (win),
    .frm_o      (frm_o),
    .txd_o      (txd_o),
    .drive_o    (drive),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o)
  );

  assign oe_o = ~tte_i | drive;
endmodule

// File: rtl/ssp_tx_engine_chk.sv
module ssp_tx_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tte_i,
  input logic late_i,
  input logic ld_ready_o,
  input logic sclk_o,
  input logic frm_o,
  input logic txd_o,
  input logic oe_o,
  input logic rx_valid_o
);
  AST_TXD_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(sclk_o) |-> $stable(txd_o)); // R2
  AST_FRM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frm_o) |-> $rose(sclk_o)); // R3
  AST_FRM_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frm_o) |-> $rose(sclk_o)); // R3
  AST_FRM_ONE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) && $past(frm_o) |-> !frm_o); // R3
  AST_ALWAYS_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tte_i |-> oe_o); // R4
  AST_OE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_o) && $stable(tte_i) |-> !$stable(sclk_o)); // R5
  AST_EARLY_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tte_i && !late_i && $stable(tte_i) && $fell(oe_o) |-> $fell(sclk_o)); // R6
  AST_LATE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tte_i && late_i && $stable(tte_i) && $fell(oe_o) |-> $rose(sclk_o)); // R7
  AST_NO_LOAD_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_o |-> !ld_ready_o); // R8
  AST_RXV_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $fell(sclk_o)); // R10
endmodule

bind ssp_tx_engine ssp_tx_engine_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tte_i      (tte_i),
  .late_i     (late_i),
  .ld_ready_o (ld_ready_o),
  .sclk_o     (sclk_o),
  .frm_o      (frm_o),
  .txd_o      (txd_o),
  .oe_o       (oe_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/test_ssp_tx_engine.sv
module test_ssp_tx_engine;
  localparam int MAX_W = 32;
  localparam int DIV_W = 8;
  localparam int LEN_W = 5;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [DIV_W-1:0] div_i = '0;
  logic             tte_i = 1'b0;
  logic             late_i = 1'b0;
  logic             ld_valid_i = 1'b0;
  logic [MAX_W-1:0] ld_data_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic             ld_ready_o, sclk_o, frm_o, txd_o, oe_o, rxd_i, rx_valid_o;
  logic [MAX_W-1:0] rx_data_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  assign rxd_i = ~txd_o;  // inverted loopback

  ssp_tx_engine i_ssp_tx_engine (.*);

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbits_of(input int len);
    return (len < 3) ? 4 : len + 1;
  endfunction

  function automatic logic [31:0] mask_of(input int nb);
    logic [63:0] m;
    m = (64'd1 << nb) - 64'd1;
    return m[31:0];
  endfunction

  // expected-word queue
  logic [31:0] q_word[64];
  int          q_len[64];
  int          wr_p = 0, rd_p = 0, pend_cnt = 0;

  // monitor state
  int          mst = 0, bit_i = 0, nb = 0;
  logic [31:0] acc, exp_word;
  bit          m_tte, m_late;
  logic        prev_sclk = 1'b0;
  int          half_cnt = 0;
  bit          half_ok = 0;
  int          cur_div = 0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      bit rise, fall;
      rise = !prev_sclk && sclk_o;
      fall = prev_sclk && !sclk_o;
      half_cnt++;
      if (sclk_o != prev_sclk) begin
        if (half_ok) chk(half_cnt == cur_div + 1, "R2 half period", half_cnt, cur_div + 1);
        half_ok  = 1;
        half_cnt = 0;
      end
      if (rise) begin
        if (mst == 2 && bit_i == nb) begin
          chk(oe_o == !m_tte, "R7 oe after LSB", oe_o, !m_tte);
          if (pend_cnt > 0) chk(frm_o, "R9 back-to-back frame", frm_o, 1);
          else begin
            chk(!frm_o, "R9 no frame when empty", frm_o, 0);
            if (!m_tte) chk(txd_o == exp_word[0], "R4 idle holds LSB", txd_o, exp_word[0]);
          end
          mst = 0;
        end else if (mst == 1) begin
          chk(!frm_o, "R3 frame one period", frm_o, 0);
          mst = 2; bit_i = 0; acc = '0;
        end
        if (mst == 2 && bit_i < nb) begin
          acc = {acc[30:0], txd_o};
          chk(oe_o, "R5 driven during bits", oe_o, 1);
          chk(ld_ready_o == (bit_i == nb - 1 && pend_cnt == 0), "R8 ready window",
              ld_ready_o, (bit_i == nb - 1 && pend_cnt == 0));
          bit_i++;
          if (bit_i == nb) chk(acc == exp_word, "R1 word MSB first", acc, exp_word);
        end
        if (mst == 0 && frm_o) begin
          if (pend_cnt == 0) chk(0, "R3 unexpected frame", frm_o, 0);
          else begin
            nb       = nbits_of(q_len[rd_p]);
            exp_word = q_word[rd_p] & mask_of(nb);
            rd_p     = (rd_p + 1) % 64;
            pend_cnt--;
            m_tte    = tte_i;
            m_late   = late_i;
            chk(oe_o == !m_tte, "R5 released in frame", oe_o, !m_tte);
            mst = 1;
          end
        end
      end
      if (fall && mst == 2 && bit_i == nb) begin
        chk(oe_o == !(m_tte && !m_late), "R6 oe mid LSB", oe_o, !(m_tte && !m_late));
        chk(rx_valid_o, "R10 rx strobe", rx_valid_o, 1);
        chk(rx_data_o == (~exp_word & mask_of(nb)), "R10 rx word", rx_data_o, ~exp_word & mask_of(nb));
      end
      prev_sclk = sclk_o;
    end
  end

  task automatic send(input logic [31:0] w, input int len, input int gap);
    repeat (gap) @(negedge clk_i);
    ld_valid_i = 1'b1;
    ld_data_i  = w;
    len_i      = LEN_W'(len);
    while (!ld_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    #1;
    q_word[wr_p] = w;
    q_len[wr_p]  = len;
    wr_p = (wr_p + 1) % 64;
    pend_cnt++;
    ld_valid_i = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk_i);
    while (pend_cnt != 0 || mst != 0) @(negedge clk_i);
    repeat (8 * (cur_div + 1)) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    // reset state
    chk(sclk_o == 1'b0, "R2 reset sclk", sclk_o, 0);
    chk(frm_o == 1'b0, "R3 reset frame", frm_o, 0);
    chk(ld_ready_o == 1'b1, "R8 reset ready", ld_ready_o, 1);
    chk(rx_valid_o == 1'b0, "R10 reset strobe", rx_valid_o, 0);
    chk(oe_o == 1'b1, "R4 reset driven", oe_o, 1);
    rst_ni = 1'b1;
    for (int cfg = 0; cfg < 4; cfg++) begin
      tte_i   = cfg[1];
      late_i  = cfg[0];
      div_i   = DIV_W'(cfg);
      cur_div = cfg;
      half_ok = 0;
      @(negedge clk_i);
      chk(oe_o == !tte_i, "R5 idle oe", oe_o, !tte_i);
      send(32'hFFFF_FFFF, 31, 2);
      send(32'h0000_0005, 0, 0);
      send(32'h0000_000A, 2, 0);
      send(32'h8000_0001, 31, 0);
      for (int k = 0; k < 22; k++) begin
        int gap;
        gap = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(1, 40));
        send($urandom, int'($urandom_range(3, 31)), gap);
      end
      drain();
    end
    finish_run();
  end
endmodule